// File: doc/BRIEF.md
# External Bus-Release Request Handshake

This block connects an external requesting device to a four-channel DMA controller. The device can do one of three things. It can raise a bus-release request to ask for the data bus so that it can send in a request descriptor. It can raise a transfer-request line alone for an ordinary DMA request. It can raise both lines in the same cycle to send a direct request to channel 2.

When a bus-release request is granted, the block answers with a one-cycle bus-available pulse. Two cycles after that pulse, the device may drive the data bus. If the transfer-request line is high in exactly that cycle, the bus word is captured as a descriptor and handed to the DMA engine with a one-cycle valid pulse. The two low bits of the word name the target channel.

In the reverse direction, the DMA engine signals an acknowledgment per channel. The block queues at most one acknowledgment per channel and replays each one to the device as a reply strobe, together with a two-bit channel number.

Top module: `dmaExtHandshake`

## Requirements
- R1: While and after synchronous active-high reset `rst`, all outputs are 0 until new stimulus arrives.
- R2: In idle, `busRelReq` high with `xferReq` low produces `busAvail` high for exactly one cycle, in the cycle after the request.
- R3: From the `busAvail` cycle through the cycle two after it, `busRelReq` is ignored. No further `busAvail` and no `directReq` are produced.
- R4: If `xferReq` is high in the cycle two after `busAvail`, then in the next cycle `descValid` pulses for one cycle and `descWord` holds the `dataBus` value from the sampled cycle. `descChan` equals bits [1:0] of that word.
- R5: `xferReq` in the `busAvail` cycle or in the cycle after it produces no `dmaReq`, no `directReq` and no `descValid`. If `xferReq` is absent at the sampling offset, no `descValid` follows.
- R6: In idle, `xferReq` high with `busRelReq` low produces a one-cycle `dmaReq` pulse in the next cycle.
- R7: In idle, `busRelReq` and `xferReq` high together produce a one-cycle `directReq` pulse (a request to channel 2) in the next cycle, with no `busAvail` and no `dmaReq`.
- R8: An `ackIn[c]` pulse in cycle t, when nothing else is pending, gives `replyStrobe` high with `replyChan` equal to c in cycle t+2.
- R9: Pending acknowledgments are replayed one per cycle, the lowest channel number first.
- R10: A second acknowledgment for a channel that is already pending is merged and yields only one reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busRelReq | input | 1 | Data-bus release request from the device |
| xferReq | input | 1 | Transfer-request line from the device |
| dataBus | input | 32 | Data bus driven by the device |
| ackIn | input | 4 | Per-channel acknowledgment pulses from the DMA engine |
| busAvail | output | 1 | One-cycle bus-available notification |
| dmaReq | output | 1 | Ordinary DMA request pulse |
| directReq | output | 1 | Direct request to channel 2 pulse |
| descValid | output | 1 | Descriptor-captured pulse |
| descWord | output | 32 | Captured descriptor word |
| descChan | output | 2 | Channel field of the descriptor (bits [1:0]) |
| replyStrobe | output | 1 | Reply strobe to the device |
| replyChan | output | 2 | Channel number accompanying the reply strobe |

## Verification
The hardest situation to bring about is a transfer-request pulse that lands inside the open bus-release window but away from the sampling cycle, while fresh release requests arrive at the same time. The stimulus first grants the bus. It then sweeps the single transfer-request pulse across every offset from the `busAvail` cycle to two cycles past the window, and keeps `busRelReq` high throughout the window. At each offset, exactly one of three outcomes is expected: a descriptor, an ordinary request, or nothing. For the reply queue, every nonempty acknowledgment mask is applied so that the drain order can be compared against the set bits. A back-to-back repeat acknowledgment then exercises merging.

// File: rtl/dmaHsPkg.sv
package dmaHsPkg;
  typedef struct packed {
    logic grantBus;
    logic captureDesc;
    logic plainReq;
    logic directReq;
  } hsStrobes_t;
endpackage

// File: rtl/hsCtl.sv
module hsCtl
  import dmaHsPkg::*;
#(
  parameter int WIN_OFS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       busRelReq,
  input  logic       xferReq,
  output hsStrobes_t strb
);
  localparam int CW = $clog2(WIN_OFS + 2);

  logic [CW-1:0] winCnt;
  logic          idle;

  assign idle = (winCnt == '0);

  always_comb begin
    strb.grantBus    = idle & busRelReq & ~xferReq;
    strb.directReq   = idle & busRelReq & xferReq;
    strb.plainReq    = idle & ~busRelReq & xferReq;
    strb.captureDesc = (winCnt == CW'(1)) & xferReq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      winCnt <= '0;
    end else if (strb.grantBus) begin
      winCnt <= CW'(WIN_OFS + 1);
    end else if (!idle) begin
      winCnt <= winCnt - CW'(1);
    end
  end
endmodule

// File: rtl/hsDp.sv
module hsDp
  import dmaHsPkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  hsStrobes_t    strb,
  input  logic [DW-1:0] dataBus,
  output logic          busAvail,
  output logic          dmaReq,
  output logic          directReq,
  output logic          descValid,
  output logic [DW-1:0] descWord
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busAvail  <= 1'b0;
      dmaReq    <= 1'b0;
      directReq <= 1'b0;
      descValid <= 1'b0;
      descWord  <= '0;
    end else begin
      busAvail  <= strb.grantBus;
      dmaReq    <= strb.plainReq;
      directReq <= strb.directReq;
      descValid <= strb.captureDesc;
      if (strb.captureDesc) descWord <= dataBus;
    end
  end
endmodule

// File: rtl/replyArb.sv
module replyArb #(
  parameter int NCH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCH-1:0]         ackIn,
  output logic                   replyStrobe,
  output logic [$clog2(NCH)-1:0] replyChan
);
  localparam int CHW = $clog2(NCH);

  logic [NCH-1:0] pending;
  logic [NCH-1:0] grantMask;
  logic [CHW-1:0] grantIdx;
  logic           anyPend;

  always_comb begin
    grantMask = '0;
    grantIdx  = '0;
    anyPend   = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (pending[i] && !anyPend) begin
        anyPend      = 1'b1;
        grantMask[i] = 1'b1;
        grantIdx     = CHW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending     <= '0;
      replyStrobe <= 1'b0;
      replyChan   <= '0;
    end else begin
      pending     <= (pending & ~grantMask) | ackIn;
      replyStrobe <= anyPend;
      replyChan   <= anyPend ? grantIdx : replyChan;
    end
  end
endmodule

// File: rtl/dmaExtHandshake.sv
module dmaExtHandshake
  import dmaHsPkg::*;
#(
  parameter int DW      = 32,
  parameter int NCH     = 4,
  parameter int WIN_OFS = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   busRelReq,
  input  logic                   xferReq,
  input  logic [DW-1:0]          dataBus,
  input  logic [NCH-1:0]         ackIn,
  output logic                   busAvail,
  output logic                   dmaReq,
  output logic                   directReq,
  output logic                   descValid,
  output logic [DW-1:0]          descWord,
  output logic [$clog2(NCH)-1:0] descChan,
  output logic                   replyStrobe,
  output logic [$clog2(NCH)-1:0] replyChan
);
  localparam int CHW = $clog2(NCH);

  hsStrobes_t strb;

  hsCtl #(.WIN_OFS(WIN_OFS)) u_ctl (
    .clk(clk), .rst(rst), .busRelReq(busRelReq), .xferReq(xferReq), .strb(strb)
  );

  hsDp #(.DW(DW)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .dataBus(dataBus),
    .busAvail(busAvail), .dmaReq(dmaReq), .directReq(directReq),
    .descValid(descValid), .descWord(descWord)
  );

  replyArb #(.NCH(NCH)) u_arb (
    .clk(clk), .rst(rst), .ackIn(ackIn),
    .replyStrobe(replyStrobe), .replyChan(replyChan)
  );

  assign descChan = descWord[CHW-1:0];
endmodule

// File: rtl/dmaExtHandshake_chk.sv
module dmaExtHandshake_chk (
  input logic clk,
  input logic rst,
  input logic busRelReq,
  input logic xferReq,
  input logic busAvail,
  input logic dmaReq,
  input logic directReq,
  input logic descValid
);
  // R2
  busavail_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    busAvail |=> !busAvail);

  // R3
  busavail_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    busAvail |-> !$past(busAvail, 2) && !$past(busAvail, 3));

  // R4
  desc_offset_chk: assert property (@(posedge clk) disable iff (rst)
    descValid |-> $past(busAvail, 3) && $past(xferReq));

  // R6
  plain_req_chk: assert property (@(posedge clk) disable iff (rst)
    dmaReq |-> $past(xferReq) && !$past(busRelReq));

  // R7
  direct_req_chk: assert property (@(posedge clk) disable iff (rst)
    directReq |-> $past(xferReq) && $past(busRelReq));

  // R7
  req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busAvail, dmaReq, directReq, descValid}));
endmodule

bind dmaExtHandshake dmaExtHandshake_chk u_chk (
  .clk(clk), .rst(rst), .busRelReq(busRelReq), .xferReq(xferReq),
  .busAvail(busAvail), .dmaReq(dmaReq), .directReq(directReq),
  .descValid(descValid)
);

// File: tb/dmaExtHandshake_tb.sv
module dmaExtHandshake_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        busRelReq, xferReq;
  logic [31:0] dataBus;
  logic [3:0]  ackIn;
  logic        busAvail, dmaReq, directReq, descValid, replyStrobe;
  logic [31:0] descWord;
  logic [1:0]  descChan, replyChan;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dmaExtHandshake u_dut (
    .clk(clk), .rst(rst), .busRelReq(busRelReq), .xferReq(xferReq),
    .dataBus(dataBus), .ackIn(ackIn), .busAvail(busAvail), .dmaReq(dmaReq),
    .directReq(directReq), .descValid(descValid), .descWord(descWord),
    .descChan(descChan), .replyStrobe(replyStrobe), .replyChan(replyChan)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic rel, input logic xr, input logic [31:0] d, input logic [3:0] a);
    busRelReq = rel; xferReq = xr; dataBus = d; ackIn = a;
    @(posedge clk); #1;
  endtask

  task automatic chkReqs(input string req, input logic eAv, input logic eDma,
                         input logic eDir, input logic eDesc);
    chk({req, " busAvail"}, {31'b0, busAvail}, {31'b0, eAv});
    chk({req, " dmaReq"}, {31'b0, dmaReq}, {31'b0, eDma});
    chk({req, " directReq"}, {31'b0, directReq}, {31'b0, eDir});
    chk({req, " descValid"}, {31'b0, descValid}, {31'b0, eDesc});
  endtask

  initial begin
    #150000;
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    busRelReq = 0; xferReq = 0; dataBus = '0; ackIn = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chkReqs("R1", 0, 0, 0, 0);
    chk("R1 replyStrobe", {31'b0, replyStrobe}, 32'h0);
    chk("R1 descWord", descWord, 32'h0);
    rst = 1'b0;
    cyc(0, 0, 0, 0);
    chkReqs("R1 idle", 0, 0, 0, 0);

    // R2..R6 sweep of the single xferReq pulse across the window
    for (int k = 0; k <= 4; k++) begin
      cyc(1, 0, 32'h0, 0);
      chkReqs("R2 grant", 1, 0, 0, 0);
      for (int j = 0; j <= 4; j++) begin
        logic [31:0] val;
        val = 32'hA5C30000 + 32'(k * 16 + j);
        cyc(j <= 2, j == k, val, 0);
        // R3/R5 in window; R4 at offset 2; R6 once idle again
        chkReqs(j <= 2 ? "R3_R4_R5" : "R6", 0, (j == k) && (j >= 3), 0, (k == 2) && (j == 2));
        if (k == 2 && j == 2) begin
          chk("R4 descWord", descWord, val);
          chk("R4 descChan", {30'b0, descChan}, {30'b0, val[1:0]});
        end
      end
      cyc(0, 0, 0, 0);
      chkReqs("R2 settle", 0, 0, 0, 0);
    end

    // R7 and R6 idle combinations
    for (int m = 0; m < 4; m++) begin
      logic rel, xr;
      rel = m[1]; xr = m[0];
      if (rel && !xr) continue;
      cyc(rel, xr, 0, 0);
      chkReqs(rel ? "R7" : "R6", 0, !rel && xr, rel && xr, 0);
      cyc(0, 0, 0, 0);
      chkReqs("R7 after", 0, 0, 0, 0);
    end

    // R8/R9 every nonempty ack mask, drained lowest first
    for (int m = 1; m < 16; m++) begin
      cyc(0, 0, 0, 4'(m));
      chk("R8 no early reply", {31'b0, replyStrobe}, 32'h0);
      for (int c = 0; c < 4; c++) begin
        if (m[c]) begin
          cyc(0, 0, 0, 0);
          chk(m == (1 << c) ? "R8 strobe" : "R9 strobe", {31'b0, replyStrobe}, 32'h1);
          chk(m == (1 << c) ? "R8 chan" : "R9 chan", {30'b0, replyChan}, 32'(c));
        end
      end
      cyc(0, 0, 0, 0);
      chk("R9 drained", {31'b0, replyStrobe}, 32'h0);
    end

    // R10 repeat ack on a pending channel is merged
    cyc(0, 0, 0, 4'b0011);
    cyc(0, 0, 0, 4'b0010);
    chk("R10 first chan", {30'b0, replyChan}, 32'h0);
    chk("R10 first strobe", {31'b0, replyStrobe}, 32'h1);
    cyc(0, 0, 0, 0);
    chk("R10 second chan", {30'b0, replyChan}, 32'h1);
    chk("R10 second strobe", {31'b0, replyStrobe}, 32'h1);
    cyc(0, 0, 0, 0);
    chk("R10 merged", {31'b0, replyStrobe}, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule